// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Halt Wake

This block arbitrates five interrupt sources for a small 8-bit processor core. Each source owns one bit in a flag register, and an enable register selects which flags may act. A source is pending when its flag and enable bits are both set. Among the pending sources, the one with the lowest index wins. When the master enable is on and no earlier dispatch sequence is still running, the controller selects that source. It presents the restart address to the core, clears that source's flag and drops the master enable, all at one clock edge.

The core reports its state on a two-bit input. A halted core is released by any pending source, whether or not the master enable is on. If the master enable is on at that moment, the same step also dispatches. A stopped core is left alone. A dispatch is followed by a five-cycle sequence shown on a busy output. During that sequence no further decision is taken.

Top module: `irq_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, enable, flags, master enable, read data, vector, wake, dispatch and busy are all zero.
- R2: Register select 0 is the enable register: all 8 bits are writable and read back. Register select 1 is the flag register: bits 4:0 are writable and bits 7:5 read as ones. Read data is registered, so it shows the selected register one edge after the select is applied. Source i is pending when bit i is set in both registers.
- R3: The pending source with the lowest index is serviced, and the vector output becomes 0x0040 + 8*i (0x40, 0x48, 0x50, 0x58, 0x60). The vector holds its value until the next dispatch.
- R4: A dispatch clears the master enable and the serviced flag bit, and leaves the other flag bits unchanged.
- R5: In run state (code 0), a dispatch occurs only when the master enable is set.
- R6: In halt state (code 1), any pending source pulses wake, whatever the master enable. If the master enable is set, dispatch pulses at the same edge.
- R7: In stop state (code 2), and in code 3, neither wake nor dispatch is ever raised.
- R8: Busy is high for exactly 5 cycles starting with the dispatch cycle. The next dispatch can come no sooner than 5 cycles after the previous one.
- R9: A request input sets its flag bit even when a software write or a dispatch clears that bit at the same edge.
- R10: The set-enable input raises the master enable and the clear-enable input lowers it. A dispatch at the same edge overrides a set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 5 | Request pulses, one per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 enable, 1 flags |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 1 | Read target: 0 enable, 1 flags |
| rd_data_o | output | 8 | Registered read data |
| ime_set_i | input | 1 | Raise master enable |
| ime_clr_i | input | 1 | Lower master enable |
| cpu_state_i | input | 2 | Core state: 0 run, 1 halt, 2 stop, 3 off |
| wake_o | output | 1 | One-cycle pulse: halted core must resume |
| dispatch_o | output | 1 | One-cycle pulse: jump to vector |
| busy_o | output | 1 | Dispatch sequence in progress |
| vector_o | output | 16 | Restart address of last dispatch |
| ime_o | output | 1 | Master enable state |

## Verification
A request is captured in its flag at the first edge. Wake, dispatch and the vector follow at the second edge, so a stimulus applied at one falling edge is judged two falling edges later. Read data trails the read select by one edge, and busy stays high for the five cycles that begin with the dispatch cycle. The bench drives inputs on the falling edge and advances its behavioural model on the rising edge. It compares every output on the next falling edge, so each expected value is compared in the cycle in which it is due.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  typedef enum logic [1:0] {
    CPU_RUN  = 2'd0,
    CPU_HALT = 2'd1,
    CPU_STOP = 2'd2,
    CPU_OFF  = 2'd3
  } cpu_state_e;

  localparam logic SEL_ENABLE = 1'b0;
  localparam logic SEL_FLAG   = 1'b1;

endpackage

// File: rtl/irq_prio.sv
// Fixed-priority picker: lowest index wins.
module irq_prio #(
  parameter int NUM_SRC = 5,
  parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic [NUM_SRC-1:0] grant_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o
);

  logic [NUM_SRC:0] below;

  assign below[0] = 1'b0;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
    assign below[g+1]  = below[g] | pend_i[g];
    assign grant_o[g]  = pend_i[g] & ~below[g];
  end

  assign any_o = below[NUM_SRC];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end

endmodule

// File: rtl/irq_regs.sv
// Enable, flag and master-enable storage with registered read port.
module irq_regs #(
  parameter int NUM_SRC = 5,
  parameter int REG_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               wr_en_i,
  input  logic               wr_sel_i,
  input  logic [REG_W-1:0]   wr_data_i,
  input  logic               rd_sel_i,
  input  logic               ime_set_i,
  input  logic               ime_clr_i,
  input  logic               svc_i,
  input  logic [NUM_SRC-1:0] svc_mask_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic               ime_o,
  output logic [REG_W-1:0]   rd_data_o
);

  import irq_ctrl_pkg::*;

  localparam int PAD_W = REG_W - NUM_SRC;

  logic [REG_W-1:0]   en_q;
  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] flag_d;
  logic               ime_q;

  // Flag next state: write, then service clear, then requests on top.
  always_comb begin
    flag_d = flag_q;
    if (wr_en_i && wr_sel_i == SEL_FLAG) flag_d = wr_data_i[NUM_SRC-1:0];
    if (svc_i) flag_d = flag_d & ~svc_mask_i;
    flag_d = flag_d | req_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      flag_q    <= '0;
      ime_q     <= 1'b0;
      rd_data_o <= '0;
    end else begin
      if (wr_en_i && wr_sel_i == SEL_ENABLE) en_q <= wr_data_i;
      flag_q <= flag_d;
      if (svc_i)          ime_q <= 1'b0;
      else if (ime_clr_i) ime_q <= 1'b0;
      else if (ime_set_i) ime_q <= 1'b1;
      if (rd_sel_i == SEL_FLAG) rd_data_o <= {{PAD_W{1'b1}}, flag_q};
      else                      rd_data_o <= en_q;
    end
  end

  assign pend_o = en_q[NUM_SRC-1:0] & flag_q;
  assign ime_o  = ime_q;

endmodule

// File: rtl/irq_seq.sv
// Decision, wake/dispatch pulses, vector register and sequence timer.
module irq_seq #(
  parameter int          NUM_SRC  = 5,
  parameter int          IDX_W    = 3,
  parameter int          ADDR_W   = 16,
  parameter int          VEC_BASE = 'h40,
  parameter int          VEC_STEP = 8,
  parameter int          SEQ_LEN  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              any_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [1:0]        cpu_state_i,
  input  logic              ime_i,
  output logic              take_o,
  output logic              wake_o,
  output logic              dispatch_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] vector_o
);

  import irq_ctrl_pkg::*;

  localparam int CNT_W = $clog2(SEQ_LEN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             blocked;
  logic             live;
  logic             wake_d;
  logic [ADDR_W-1:0] vec_d;

  assign blocked = (cnt_q > CNT_W'(1));
  assign live    = (cpu_state_i == CPU_RUN) || (cpu_state_i == CPU_HALT);
  assign take_o  = any_i && ime_i && live && !blocked;
  assign wake_d  = any_i && (cpu_state_i == CPU_HALT) && !blocked;
  assign vec_d   = ADDR_W'(VEC_BASE) + ADDR_W'(idx_i) * ADDR_W'(VEC_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      wake_o     <= 1'b0;
      dispatch_o <= 1'b0;
      vector_o   <= '0;
    end else begin
      wake_o     <= wake_d;
      dispatch_o <= take_o;
      if (take_o) begin
        vector_o <= vec_d;
        cnt_q    <= CNT_W'(SEQ_LEN);
      end else if (cnt_q != '0) begin
        cnt_q    <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int NUM_SRC  = 5,
  parameter int REG_W    = 8,
  parameter int ADDR_W   = 16,
  parameter int VEC_BASE = 'h40,
  parameter int VEC_STEP = 8,
  parameter int SEQ_LEN  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               wr_en_i,
  input  logic               wr_sel_i,
  input  logic [REG_W-1:0]   wr_data_i,
  input  logic               rd_sel_i,
  output logic [REG_W-1:0]   rd_data_o,
  input  logic               ime_set_i,
  input  logic               ime_clr_i,
  input  logic [1:0]         cpu_state_i,
  output logic               wake_o,
  output logic               dispatch_o,
  output logic               busy_o,
  output logic [ADDR_W-1:0]  vector_o,
  output logic               ime_o
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] grant;
  logic [IDX_W-1:0]   idx;
  logic               any;
  logic               take;

  irq_regs #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req_i),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .rd_sel_i   (rd_sel_i),
    .ime_set_i  (ime_set_i),
    .ime_clr_i  (ime_clr_i),
    .svc_i      (take),
    .svc_mask_i (grant),
    .pend_o     (pend),
    .ime_o      (ime_o),
    .rd_data_o  (rd_data_o)
  );

  irq_prio #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_prio (
    .pend_i  (pend),
    .grant_o (grant),
    .idx_o   (idx),
    .any_o   (any)
  );

  irq_seq #(
    .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
    .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP), .SEQ_LEN(SEQ_LEN)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .any_i       (any),
    .idx_i       (idx),
    .cpu_state_i (cpu_state_i),
    .ime_i       (ime_o),
    .take_o      (take),
    .wake_o      (wake_o),
    .dispatch_o  (dispatch_o),
    .busy_o      (busy_o),
    .vector_o    (vector_o)
  );

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int NUM_SRC  = 5,
  parameter int ADDR_W   = 16,
  parameter int VEC_BASE = 'h40,
  parameter int VEC_STEP = 8,
  parameter int SEQ_LEN  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        cpu_state_i,
  input logic              ime_o,
  input logic              wake_o,
  input logic              dispatch_o,
  input logic              busy_o,
  input logic [ADDR_W-1:0] vector_o
);

  localparam int GAP_W = $clog2(SEQ_LEN + 2);

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst)                         gap_q <= GAP_W'(SEQ_LEN);
    else if (dispatch_o)             gap_q <= GAP_W'(1);
    else if (gap_q < GAP_W'(SEQ_LEN)) gap_q <= gap_q + GAP_W'(1);
  end

  // R5
  dispatch_needs_ime_chk: assert property (@(posedge clk) disable iff (rst)
    dispatch_o |-> $past(ime_o));

  // R4
  dispatch_drops_ime_chk: assert property (@(posedge clk) disable iff (rst)
    dispatch_o |-> !ime_o);

  // R7
  stop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (dispatch_o || wake_o) |-> ($past(cpu_state_i) == 2'd0 || $past(cpu_state_i) == 2'd1));

  // R6
  wake_from_halt_chk: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> $past(cpu_state_i) == 2'd1);

  // R3
  vector_legal_chk: assert property (@(posedge clk) disable iff (rst)
    dispatch_o |-> (int'(vector_o) >= VEC_BASE &&
                    int'(vector_o) <= VEC_BASE + VEC_STEP * (NUM_SRC - 1) &&
                    (int'(vector_o) - VEC_BASE) % VEC_STEP == 0));

  // R8
  dispatch_gap_chk: assert property (@(posedge clk) disable iff (rst)
    dispatch_o |-> (gap_q >= GAP_W'(SEQ_LEN)));

  // R8
  busy_with_dispatch_chk: assert property (@(posedge clk) disable iff (rst)
    dispatch_o |-> busy_o);

endmodule

bind irq_ctrl irq_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE),
  .VEC_STEP(VEC_STEP), .SEQ_LEN(SEQ_LEN)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cpu_state_i (cpu_state_i),
  .ime_o       (ime_o),
  .wake_o      (wake_o),
  .dispatch_o  (dispatch_o),
  .busy_o      (busy_o),
  .vector_o    (vector_o)
);

// File: tb/test_irq_ctrl.sv
`timescale 1ns/1ps
module test_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  req_i = '0;
  logic        wr_en_i = 1'b0;
  logic        wr_sel_i = 1'b0;
  logic [7:0]  wr_data_i = '0;
  logic        rd_sel_i = 1'b0;
  logic [7:0]  rd_data_o;
  logic        ime_set_i = 1'b0;
  logic        ime_clr_i = 1'b0;
  logic [1:0]  cpu_state_i = 2'd0;
  logic        wake_o, dispatch_o, busy_o, ime_o;
  logic [15:0] vector_o;

  always #2.5 clk = ~clk;

  irq_ctrl i_irq_ctrl (
    .clk(clk), .rst(rst), .req_i(req_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
    .ime_set_i(ime_set_i), .ime_clr_i(ime_clr_i), .cpu_state_i(cpu_state_i),
    .wake_o(wake_o), .dispatch_o(dispatch_o), .busy_o(busy_o),
    .vector_o(vector_o), .ime_o(ime_o)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 0;

  // Behavioural reference model.
  int m_en, m_flag, m_ime, m_cnt, m_disp, m_wake, m_vec, m_rd;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_en = 0; m_flag = 0; m_ime = 0; m_cnt = 0;
      m_disp = 0; m_wake = 0; m_vec = 0; m_rd = 0;
    end else begin
      int pend, idx, nflag, may, go;
      pend = m_en & m_flag & 'h1F;
      idx  = -1;
      for (int i = 4; i >= 0; i--) if (pend[i]) idx = i;
      may  = (m_cnt <= 1);
      go   = (idx >= 0) && may && m_ime && (cpu_state_i == 2'd0 || cpu_state_i == 2'd1);
      m_rd = rd_sel_i ? ('hE0 | m_flag) : m_en;
      m_wake = (idx >= 0) && may && (cpu_state_i == 2'd1);
      m_disp = go;
      nflag = (wr_en_i && wr_sel_i) ? (wr_data_i & 'h1F) : m_flag;
      if (go) nflag = nflag & ~(1 << idx);
      nflag = nflag | req_i;
      if (wr_en_i && !wr_sel_i) m_en = wr_data_i;
      m_flag = nflag;
      if (go) begin m_vec = 'h40 + 8 * idx; m_cnt = 5; end
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (go) m_ime = 0;
      else if (ime_clr_i) m_ime = 0;
      else if (ime_set_i) m_ime = 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Every-cycle comparison against the model.
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 rd_data", rd_data_o, m_rd);
      chk("R3 vector", vector_o, m_vec);
      chk("R5 dispatch", dispatch_o, m_disp);
      chk("R6 wake", wake_o, m_wake);
      chk("R8 busy", busy_o, (m_cnt != 0));
      chk("R10 ime", ime_o, m_ime);
    end
  end

  task automatic tick();
    @(negedge clk);
    req_i = '0; wr_en_i = 0; ime_set_i = 0; ime_clr_i = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) tick();
    // R1 while in reset
    chk("R1 dispatch", dispatch_o, 0); chk("R1 ime", ime_o, 0);
    chk("R1 vector", vector_o, 0);     chk("R1 rd", rd_data_o, 0);
    rst = 0;
    tick();
    chk("R1 busy", busy_o, 0); chk("R1 wake", wake_o, 0);

    // R2 enable readback
    wr_en_i = 1; wr_sel_i = 0; wr_data_i = 8'h1F; tick();
    rd_sel_i = 0; tick(); tick();
    chk("R2 enable read", rd_data_o, 8'h1F);

    // R5 pending without master enable: no dispatch
    req_i = 5'h08; tick(); tick(); tick();
    chk("R5 no dispatch", dispatch_o, 0);
    rd_sel_i = 1; tick(); tick();
    chk("R2 flag read", rd_data_o, 8'hE8);

    // R3/R4 dispatch source 3
    ime_set_i = 1; tick(); tick();
    chk("R3 vec src3", vector_o, 16'h58); chk("R4 ime cleared", ime_o, 0);
    chk("R5 dispatch", dispatch_o, 1);
    tick(); chk("R4 flag cleared", rd_data_o, 8'hE0);
    repeat (6) tick();

    // R3 priority, R8 spacing
    req_i = 5'h12; ime_set_i = 1; tick(); tick();
    chk("R3 vec src1", vector_o, 16'h48);
    ime_set_i = 1; n = 0;
    for (int k = 0; k < 12; k++) begin
      tick(); n++;
      if (dispatch_o) break;
    end
    chk("R8 gap", n, 5);
    chk("R3 vec src4", vector_o, 16'h60);
    repeat (6) tick();

    // R6 halt wake without master enable
    cpu_state_i = 2'd1; req_i = 5'h01; tick(); tick();
    chk("R6 wake", wake_o, 1); chk("R6 no dispatch", dispatch_o, 0);
    cpu_state_i = 2'd0;
    wr_en_i = 1; wr_sel_i = 1; wr_data_i = 8'h00; tick(); tick();

    // R6 halt wake with master enable dispatches too
    ime_set_i = 1; tick();
    cpu_state_i = 2'd1; req_i = 5'h04; tick(); tick();
    chk("R6 wake+disp", wake_o & dispatch_o, 1);
    chk("R6 vec src2", vector_o, 16'h50);
    cpu_state_i = 2'd0; repeat (6) tick();

    // R7 stop
    cpu_state_i = 2'd2; ime_set_i = 1; req_i = 5'h01; tick();
    for (int k = 0; k < 4; k++) begin
      tick(); chk("R7 stop quiet", wake_o | dispatch_o, 0);
    end
    cpu_state_i = 2'd3; tick(); tick();
    chk("R7 off quiet", wake_o | dispatch_o, 0);
    cpu_state_i = 2'd0; tick(); tick();
    chk("R7 run resumes", vector_o, 16'h40);
    repeat (6) tick();

    // R9 request beats write-clear
    rd_sel_i = 1; wr_en_i = 1; wr_sel_i = 1; wr_data_i = 8'h00; req_i = 5'h02; tick();
    tick(); chk("R9 req vs write", rd_data_o, 8'hE2);
    // R9 request beats dispatch-clear
    ime_set_i = 1; tick();
    req_i = 5'h02; tick();
    chk("R9 dispatch", dispatch_o, 1);
    tick(); chk("R9 req vs service", rd_data_o, 8'hE2);
    repeat (6) tick();

    // R10 dispatch beats set
    ime_set_i = 1; tick();
    ime_set_i = 1; tick();
    chk("R10 dispatch wins", ime_o, 0);
    repeat (6) tick();
    wr_en_i = 1; wr_sel_i = 1; wr_data_i = 8'h00; tick();
    ime_set_i = 1; tick(); chk("R10 set", ime_o, 1);
    ime_clr_i = 1; tick(); chk("R10 clear", ime_o, 0);

    // R2 enable masks pending
    wr_en_i = 1; wr_sel_i = 0; wr_data_i = 8'hA0; tick();
    req_i = 5'h1F; ime_set_i = 1; tick(); tick(); tick();
    chk("R2 masked", dispatch_o, 0);
    tick(); chk("R2 flags all", rd_data_o, 8'hFF);
    rd_sel_i = 0; tick(); tick(); chk("R2 enable 8 bits", rd_data_o, 8'hA0);

    // R1 reset again
    rst = 1; tick(); tick();
    rst = 0; tick();
    chk("R1 ime after reset", ime_o, 0); chk("R1 rd after reset", rd_data_o, 0);
    chk("R1 vec after reset", vector_o, 0);
    repeat (3) tick();
    finish_run();
  end

endmodule